// File: doc/BRIEF.md
# Cross-Context Register Write Unit

This block lets one hardware thread of a multithreaded core write a 32-bit value into a register that belongs to a different thread context. The issuing thread presents the value, together with a decoded destination made of a 5-bit register number `rs`, a 3-bit select code `sel`, a flag `u` (clear for the system-control register space, set for the user-visible files) and a half flag `h`. The destination context is not part of the instruction. It comes from the target-context field of a control register, which is presented on `targ_ctx`.

Before anything is written, the unit checks three things. Access to the system-control coprocessor must be enabled. The issuer must be allowed to reach the target: either it holds the multi-virtual-processor privilege, or the target context is bound to the same virtual processor as the issuer. The target index must lie inside the implemented context range. If any check fails, the strobe becomes a silent no-op, or raises a coprocessor-unusable exception when coprocessor access is disabled. When all checks pass, the `(u, sel, rs)` code is mapped onto one of the per-context register files. For 64-bit destinations, `h` picks the half that is written.

Each context holds 32 general registers, 32 64-bit floating-point registers, four accumulator sets (Lo/Hi/extension), a DSP control word, a bank of FP control words and a small 64-bit system-control array. A combinational peek port reads any of them back.

Top module: `xctx_wr_unit`

## Requirements
- R1: A one-cycle `in_valid` strobe commits its write on the same rising edge, and `done` is high for exactly the following cycle. Back-to-back strobes give back-to-back `done` pulses, and `done` never rises without a strobe.
- R2: When `cp0_en` is low, nothing is written. In the cycle after the strobe, `cu_exc` and `noop` are high and `illegal` is low, whatever the encoding.
- R3: When `mvp_priv` is low and the target's virtual-processor binding (`ctx_bind` slice for the target) differs from `issuer_vpe`, the strobe is a no-op. When `mvp_priv` is high, the same write takes effect.
- R4: When `targ_ctx` is greater than `top_ctx`, or is not below NUM_CTX, the strobe is a no-op and no context changes.
- R5: With u=0, the system-control entry at index rs*8+sel is written: h=1 writes bits 63..32 and h=0 writes bits 31..0. The other half is kept. If rs is not below CP0_RS_N, the strobe is a no-op without `illegal`.
- R6: With u=1 and sel=0, general register rs receives the value and h is ignored.
- R7: With u=1 and sel=1, an rs with bit 4 clear and rs[1:0] not equal to 3 writes accumulator index rs[3:2]*3+rs[1:0]. Set 0 is Lo/Hi/extension, and the parts are ordered lo, hi, extension. rs=16 writes DSP control. h is ignored.
- R8: With u=1 and sel=1, every other rs raises `illegal` and `noop` for one cycle, and no register changes.
- R9: With u=1 and sel=2 and `fpr_wide` high, FP register rs is written in the half chosen by h. With `fpr_wide` low, h=0 writes the low half and h=1 is illegal with no write.
- R10: With u=1 and sel=3, FP control word rs is stored exactly as given, cause bits included. The strobe completes with `noop`, `illegal` and `cu_exc` all low.
- R11: With u=1, sel values 4 to 7 are illegal and write nothing.
- R12: A write changes only its addressed register half in the target context. Other contexts and the other half are kept.
- R13: After reset, every stored register reads zero and `done`, `noop`, `illegal` and `cu_exc` are low.

Peek file codes: 0 general, 1 accumulator, 2 DSP control (index 0), 3 FP register, 4 FP control, 5 system-control (index rs*8+sel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle write strobe |
| in_data | input | DATA_W | Value from the issuer's source register |
| in_rs | input | 5 | Destination register number |
| in_sel | input | 3 | Select code |
| in_u | input | 1 | 0 = system-control space, 1 = user files |
| in_h | input | 1 | Half select for 64-bit destinations |
| cp0_en | input | 1 | System-control coprocessor access enabled |
| mvp_priv | input | 1 | Issuer may reach contexts of any virtual processor |
| fpr_wide | input | 1 | FP registers are wider than general registers |
| issuer_vpe | input | VPE_W | Virtual processor of the issuing thread |
| ctx_bind | input | NUM_CTX*VPE_W | Virtual-processor binding of each context |
| targ_ctx | input | TARG_W | Target-context field of the control register |
| top_ctx | input | TARG_W | Highest implemented context number |
| peek_ctx | input | CTX_W | Context read by the peek port |
| peek_file | input | 3 | File code read by the peek port |
| peek_idx | input | 8 | Entry read by the peek port |
| peek_data | output | 2*DATA_W | Peeked entry, zero-extended |
| done | output | 1 | Strobe completed (one cycle) |
| noop | output | 1 | Completed strobe wrote nothing |
| illegal | output | 1 | Undefined encoding |
| cu_exc | output | 1 | Coprocessor-unusable exception, unit 0 |

## Verification
Two outcomes can compete on the same strobe: the coprocessor-unusable exception and the illegal-encoding flag. The bench provokes both at once by dropping `cp0_en` while presenting u=1, sel=1, rs=3. It expects `cu_exc` and `noop` high with `illegal` low, and it confirms through the peek port that the accumulator the code would alias to is unchanged. A second collision puts a blocked permission or an out-of-range target next to an encoding that would otherwise be valid; only `noop` may rise.

// File: rtl/xcw_pkg.sv
package xcw_pkg;

   localparam int IDX_W = 8;

   typedef enum logic [2:0] {
      RF_GPR  = 3'd0,
      RF_ACC  = 3'd1,
      RF_DSPC = 3'd2,
      RF_FPR  = 3'd3,
      RF_FPCR = 3'd4,
      RF_CP0  = 3'd5,
      RF_NONE = 3'd7
   } rfile_e;

   typedef struct packed {
      rfile_e           file;
      logic [IDX_W-1:0] idx;
      logic             lane_hi;
      logic             illegal;
      logic             unimpl;
   } wdec_s;

endpackage

// File: rtl/xcw_decode.sv
module xcw_decode
   import xcw_pkg::*;
#(
   parameter int CP0_RS_N = 8,
   parameter int FPCR_N   = 32
)(
   input  logic       u,
   input  logic [2:0] sel,
   input  logic [4:0] rs,
   input  logic       h,
   input  logic       fpr_wide,
   output wdec_s      dec
);

   always_comb begin
      dec         = '0;
      dec.file    = RF_NONE;
      if (!u) begin
         if (32'(rs) < CP0_RS_N) begin
            dec.file    = RF_CP0;
            dec.idx     = {rs, sel};
            dec.lane_hi = h;
         end else begin
            dec.unimpl  = 1'b1;
         end
      end else begin
         case (sel)
            3'd0: begin
               dec.file = RF_GPR;
               dec.idx  = IDX_W'(rs);
            end
            3'd1: begin
               if (rs == 5'd16) begin
                  dec.file = RF_DSPC;
               end else if (!rs[4] && (rs[1:0] != 2'd3)) begin
                  dec.file = RF_ACC;
                  dec.idx  = IDX_W'({rs[3:2], 1'b0}) + IDX_W'(rs[3:2])
                           + IDX_W'(rs[1:0]);
               end else begin
                  dec.illegal = 1'b1;
               end
            end
            3'd2: begin
               if (fpr_wide || !h) begin
                  dec.file    = RF_FPR;
                  dec.idx     = IDX_W'(rs);
                  dec.lane_hi = fpr_wide & h;
               end else begin
                  dec.illegal = 1'b1;
               end
            end
            3'd3: begin
               if (32'(rs) < FPCR_N) begin
                  dec.file = RF_FPCR;
                  dec.idx  = IDX_W'(rs);
               end else begin
                  dec.unimpl = 1'b1;
               end
            end
            default: dec.illegal = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/xcw_guard.sv
module xcw_guard #(
   parameter int NUM_CTX = 4,
   parameter int TARG_W  = 4,
   parameter int VPE_W   = 2,
   localparam int CTX_W  = $clog2(NUM_CTX)
)(
   input  logic                     cp0_en,
   input  logic                     mvp_priv,
   input  logic [VPE_W-1:0]         issuer_vpe,
   input  logic [NUM_CTX*VPE_W-1:0] ctx_bind,
   input  logic [TARG_W-1:0]        targ_ctx,
   input  logic [TARG_W-1:0]        top_ctx,
   output logic                     cu_fault,
   output logic                     perm_block,
   output logic                     range_block,
   output logic [CTX_W-1:0]         ctx_sel
);

   logic             in_phys;
   logic [VPE_W-1:0] tgt_vpe;

   assign in_phys  = 32'(targ_ctx) < NUM_CTX;
   assign ctx_sel  = targ_ctx[CTX_W-1:0];
   assign tgt_vpe  = ctx_bind[ctx_sel*VPE_W +: VPE_W];
   assign cu_fault = !cp0_en;

   // permission is judged before range, matching the order of the checks
   assign perm_block  = cp0_en && !mvp_priv && in_phys && (tgt_vpe != issuer_vpe);
   assign range_block = cp0_en && !perm_block && (!in_phys || (targ_ctx > top_ctx));

endmodule

// File: rtl/xcw_ctx_store.sv
module xcw_ctx_store
   import xcw_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FPCR_N   = 32,
   parameter int CP0_RS_N = 8,
   localparam int CP0_N   = CP0_RS_N * 8,
   localparam int FC_W    = $clog2(FPCR_N),
   localparam int C0_W    = $clog2(CP0_N),
   localparam int NREG    = 32,
   localparam int NACC    = 12
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  rfile_e              wr_file,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                wr_hi,
   input  logic [DATA_W-1:0]   wr_data,
   input  rfile_e              rd_file,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [2*DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0]   gpr  [NREG];
   logic [2*DATA_W-1:0] fpr  [NREG];
   logic [DATA_W-1:0]   acc  [NACC];
   logic [DATA_W-1:0]   dspc;
   logic [DATA_W-1:0]   fpcr [FPCR_N];
   logic [2*DATA_W-1:0] cp0  [CP0_N];
   logic                unused_idx_bits;

   assign unused_idx_bits = ^{wr_idx, rd_idx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            gpr[i] <= '0;
            fpr[i] <= '0;
         end
         for (int i = 0; i < NACC; i++)   acc[i]  <= '0;
         for (int i = 0; i < FPCR_N; i++) fpcr[i] <= '0;
         for (int i = 0; i < CP0_N; i++)  cp0[i]  <= '0;
         dspc <= '0;
      end else if (we) begin
         case (wr_file)
            RF_GPR:  gpr[wr_idx[4:0]]       <= wr_data;
            RF_ACC:  acc[wr_idx[3:0]]       <= wr_data;
            RF_DSPC: dspc                   <= wr_data;
            RF_FPCR: fpcr[wr_idx[FC_W-1:0]] <= wr_data;
            RF_FPR: begin
               if (wr_hi) fpr[wr_idx[4:0]][2*DATA_W-1:DATA_W] <= wr_data;
               else       fpr[wr_idx[4:0]][DATA_W-1:0]        <= wr_data;
            end
            RF_CP0: begin
               if (wr_hi) cp0[wr_idx[C0_W-1:0]][2*DATA_W-1:DATA_W] <= wr_data;
               else       cp0[wr_idx[C0_W-1:0]][DATA_W-1:0]        <= wr_data;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_file)
         RF_GPR:  rd_data = {{DATA_W{1'b0}}, gpr[rd_idx[4:0]]};
         RF_ACC:  rd_data = {{DATA_W{1'b0}}, acc[rd_idx[3:0]]};
         RF_DSPC: rd_data = {{DATA_W{1'b0}}, dspc};
         RF_FPR:  rd_data = fpr[rd_idx[4:0]];
         RF_FPCR: rd_data = {{DATA_W{1'b0}}, fpcr[rd_idx[FC_W-1:0]]};
         RF_CP0:  rd_data = cp0[rd_idx[C0_W-1:0]];
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/xctx_wr_unit.sv
module xctx_wr_unit
   import xcw_pkg::*;
#(
   parameter int NUM_CTX  = 4,
   parameter int DATA_W   = 32,
   parameter int TARG_W   = 4,
   parameter int VPE_W    = 2,
   parameter int FPCR_N   = 32,
   parameter int CP0_RS_N = 8,
   localparam int CTX_W   = $clog2(NUM_CTX)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [DATA_W-1:0]        in_data,
   input  logic [4:0]               in_rs,
   input  logic [2:0]               in_sel,
   input  logic                     in_u,
   input  logic                     in_h,
   input  logic                     cp0_en,
   input  logic                     mvp_priv,
   input  logic                     fpr_wide,
   input  logic [VPE_W-1:0]         issuer_vpe,
   input  logic [NUM_CTX*VPE_W-1:0] ctx_bind,
   input  logic [TARG_W-1:0]        targ_ctx,
   input  logic [TARG_W-1:0]        top_ctx,
   input  logic [CTX_W-1:0]         peek_ctx,
   input  logic [2:0]               peek_file,
   input  logic [IDX_W-1:0]         peek_idx,
   output logic [2*DATA_W-1:0]      peek_data,
   output logic                     done,
   output logic                     noop,
   output logic                     illegal,
   output logic                     cu_exc
);

   if (NUM_CTX < 2)                           begin : g_bad_ctx   $error("NUM_CTX must be at least 2");                end
   if (CTX_W > TARG_W)                        begin : g_bad_targ  $error("TARG_W too narrow for NUM_CTX");             end
   if ((FPCR_N & (FPCR_N - 1)) != 0 || FPCR_N < 2 || FPCR_N > 32)
                                              begin : g_bad_fpcr  $error("FPCR_N must be a power of two in 2..32");    end
   if ((CP0_RS_N & (CP0_RS_N - 1)) != 0 || CP0_RS_N > 32)
                                              begin : g_bad_cp0   $error("CP0_RS_N must be a power of two up to 32");  end

   wdec_s               dec;
   logic                cu_fault, perm_block, range_block;
   logic [CTX_W-1:0]    ctx_sel;
   logic                gate_ok;
   logic                wr_en;
   logic                flag_ill;
   logic [2*DATA_W-1:0] ctx_rd [NUM_CTX];

   xcw_decode #(.CP0_RS_N(CP0_RS_N), .FPCR_N(FPCR_N)) u_dec (
      .u(in_u), .sel(in_sel), .rs(in_rs), .h(in_h), .fpr_wide(fpr_wide), .dec(dec)
   );

   xcw_guard #(.NUM_CTX(NUM_CTX), .TARG_W(TARG_W), .VPE_W(VPE_W)) u_guard (
      .cp0_en(cp0_en), .mvp_priv(mvp_priv), .issuer_vpe(issuer_vpe),
      .ctx_bind(ctx_bind), .targ_ctx(targ_ctx), .top_ctx(top_ctx),
      .cu_fault(cu_fault), .perm_block(perm_block), .range_block(range_block),
      .ctx_sel(ctx_sel)
   );

   assign gate_ok  = in_valid && !cu_fault && !perm_block && !range_block;
   assign wr_en    = gate_ok && !dec.illegal && !dec.unimpl;
   assign flag_ill = gate_ok && dec.illegal;

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic ctx_we;
      assign ctx_we = wr_en && (ctx_sel == CTX_W'(c));
      xcw_ctx_store #(.DATA_W(DATA_W), .FPCR_N(FPCR_N), .CP0_RS_N(CP0_RS_N)) u_store (
         .clk(clk), .rst_n(rst_n), .we(ctx_we),
         .wr_file(dec.file), .wr_idx(dec.idx), .wr_hi(dec.lane_hi), .wr_data(in_data),
         .rd_file(rfile_e'(peek_file)), .rd_idx(peek_idx), .rd_data(ctx_rd[c])
      );
   end

   assign peek_data = ctx_rd[peek_ctx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done    <= 1'b0;
         noop    <= 1'b0;
         illegal <= 1'b0;
         cu_exc  <= 1'b0;
      end else begin
         done    <= in_valid;
         noop    <= in_valid && !wr_en;
         illegal <= flag_ill;
         cu_exc  <= in_valid && cu_fault;
      end
   end

endmodule

// File: rtl/xcw_checker.sv
module xcw_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic cp0_en,
   input logic wr_en,
   input logic done,
   input logic noop,
   input logic illegal,
   input logic cu_exc
);

   a_r1_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);

   a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !done);

   a_r2_unusable_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cp0_en) |=> (cu_exc && noop && !illegal));

   a_r2_no_write_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cp0_en |-> !wr_en);

   a_r8_illegal_is_noop: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (noop && done && !cu_exc));

   a_r12_commit_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !noop) |-> $past(wr_en));

endmodule

bind xctx_wr_unit xcw_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cp0_en(cp0_en),
   .wr_en(wr_en), .done(done), .noop(noop), .illegal(illegal), .cu_exc(cu_exc)
);

// File: tb/tb_xctx_wr_unit.sv
module tb_xctx_wr_unit;

   localparam int NUM_CTX = 4;
   localparam int DATA_W  = 32;
   localparam int TARG_W  = 4;
   localparam int VPE_W   = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                     rst_n;
   logic                     in_valid;
   logic [DATA_W-1:0]        in_data;
   logic [4:0]               in_rs;
   logic [2:0]               in_sel;
   logic                     in_u, in_h;
   logic                     cp0_en, mvp_priv, fpr_wide;
   logic [VPE_W-1:0]         issuer_vpe;
   logic [NUM_CTX*VPE_W-1:0] ctx_bind;
   logic [TARG_W-1:0]        targ_ctx, top_ctx;
   logic [1:0]               peek_ctx;
   logic [2:0]               peek_file;
   logic [7:0]               peek_idx;
   logic [2*DATA_W-1:0]      peek_data;
   logic                     done, noop, illegal, cu_exc;

   xctx_wr_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_rs(in_rs), .in_sel(in_sel), .in_u(in_u), .in_h(in_h),
      .cp0_en(cp0_en), .mvp_priv(mvp_priv), .fpr_wide(fpr_wide),
      .issuer_vpe(issuer_vpe), .ctx_bind(ctx_bind), .targ_ctx(targ_ctx),
      .top_ctx(top_ctx), .peek_ctx(peek_ctx), .peek_file(peek_file),
      .peek_idx(peek_idx), .peek_data(peek_data), .done(done), .noop(noop),
      .illegal(illegal), .cu_exc(cu_exc)
   );

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic  noop;
      logic  ill;
      logic  cu;
      string req;
   } exp_t;
   exp_t sb[$];

   // monitor: pops one expected item per done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R1: done without a pending strobe, actual done=1 expected done=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if ({noop, illegal, cu_exc} !== {e.noop, e.ill, e.cu}) begin
               n_fail++;
               $display("FAIL %s: noop/illegal/cu actual %b%b%b expected %b%b%b",
                        e.req, noop, illegal, cu_exc, e.noop, e.ill, e.cu);
            end
         end
      end
   end

   task automatic drive(input logic [3:0] t, input logic u, input logic [2:0] s,
                        input logic [4:0] r, input logic h, input logic [31:0] d,
                        input logic e_noop, input logic e_ill, input logic e_cu,
                        input string req);
      exp_t e;
      e.noop = e_noop; e.ill = e_ill; e.cu = e_cu; e.req = req;
      sb.push_back(e);
      targ_ctx = t; in_u = u; in_sel = s; in_rs = r; in_h = h; in_data = d;
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle;
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic op(input logic [3:0] t, input logic u, input logic [2:0] s,
                     input logic [4:0] r, input logic h, input logic [31:0] d,
                     input logic e_noop, input logic e_ill, input logic e_cu,
                     input string req);
      drive(t, u, s, r, h, d, e_noop, e_ill, e_cu, req);
      idle();
   endtask

   task automatic chk_reg(input logic [1:0] c, input logic [2:0] f, input logic [7:0] i,
                          input logic [63:0] exp_v, input string req);
      peek_ctx = c; peek_file = f; peek_idx = i;
      #1;
      n_chk++;
      if (peek_data !== exp_v) begin
         n_fail++;
         $display("FAIL %s: ctx%0d file%0d idx%0d actual %h expected %h",
                  req, c, f, i, peek_data, exp_v);
      end
   endtask

   task automatic chk_bit(input logic act, input logic exp_v, input string req);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp_v);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_rs = '0; in_sel = '0;
      in_u = 1'b0; in_h = 1'b0; cp0_en = 1'b1; mvp_priv = 1'b0; fpr_wide = 1'b1;
      issuer_vpe = 2'd0; ctx_bind = {2'd1, 2'd1, 2'd0, 2'd0};
      targ_ctx = '0; top_ctx = 4'd3; peek_ctx = '0; peek_file = '0; peek_idx = '0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk_bit(done | noop | illegal | cu_exc, 1'b0, "R13 flags");
      chk_reg(2'd1, 3'd0, 8'd5, 64'd0, "R13 gpr");
      chk_reg(2'd3, 3'd5, 8'd26, 64'd0, "R13 cp0");
      rst_n = 1'b1;
      @(negedge clk);

      // R6 general register, h ignored
      op(4'd1, 1, 3'd0, 5'd5, 1, 32'hA5A5_0001, 0, 0, 0, "R6");
      chk_reg(2'd1, 3'd0, 8'd5, 64'h0000_0000_A5A5_0001, "R6");
      chk_reg(2'd0, 3'd0, 8'd5, 64'd0, "R12 other ctx");

      // R5 system-control halves
      op(4'd1, 0, 3'd2, 5'd3, 0, 32'h1111_2222, 0, 0, 0, "R5 low");
      chk_reg(2'd1, 3'd5, 8'd26, 64'h0000_0000_1111_2222, "R5 low");
      op(4'd1, 0, 3'd2, 5'd3, 1, 32'h3333_4444, 0, 0, 0, "R5 high");
      chk_reg(2'd1, 3'd5, 8'd26, 64'h3333_4444_1111_2222, "R12 half kept");
      op(4'd1, 0, 3'd0, 5'd9, 0, 32'h5555_5555, 1, 0, 0, "R5 unimpl");
      chk_reg(2'd1, 3'd5, 8'd8, 64'd0, "R5 unimpl no alias");

      // R7 accumulator map
      op(4'd1, 1, 3'd1, 5'd9,  0, 32'h0000_0777, 0, 0, 0, "R7 set2 hi");
      chk_reg(2'd1, 3'd1, 8'd7, 64'h777, "R7 set2 hi");
      op(4'd1, 1, 3'd1, 5'd16, 0, 32'h0000_BEEF, 0, 0, 0, "R7 dspc");
      chk_reg(2'd1, 3'd2, 8'd0, 64'hBEEF, "R7 dspc");
      op(4'd1, 1, 3'd1, 5'd0,  0, 32'h1234_5678, 0, 0, 0, "R7 lo");
      chk_reg(2'd1, 3'd1, 8'd0, 64'h1234_5678, "R7 lo");
      op(4'd1, 1, 3'd1, 5'd14, 1, 32'h0000_00AA, 0, 0, 0, "R7 set3 ext");
      chk_reg(2'd1, 3'd1, 8'd11, 64'hAA, "R7 set3 ext");

      // R8 undefined accumulator codes
      op(4'd1, 1, 3'd1, 5'd3,  0, 32'hDEAD_0003, 1, 1, 0, "R8 rs3");
      chk_reg(2'd1, 3'd1, 8'd3, 64'd0, "R8 rs3 no write");
      op(4'd1, 1, 3'd1, 5'd17, 0, 32'hDEAD_0011, 1, 1, 0, "R8 rs17");
      chk_reg(2'd1, 3'd2, 8'd0, 64'hBEEF, "R8 rs17 no write");
      op(4'd1, 1, 3'd1, 5'd7,  0, 32'hDEAD_0007, 1, 1, 0, "R8 rs7");

      // R9 FP registers
      op(4'd1, 1, 3'd2, 5'd4, 1, 32'hCAFE_0001, 0, 0, 0, "R9 wide hi");
      chk_reg(2'd1, 3'd3, 8'd4, 64'hCAFE_0001_0000_0000, "R9 wide hi");
      op(4'd1, 1, 3'd2, 5'd4, 0, 32'h0000_0002, 0, 0, 0, "R9 wide lo");
      chk_reg(2'd1, 3'd3, 8'd4, 64'hCAFE_0001_0000_0002, "R9 wide lo");
      fpr_wide = 1'b0;
      op(4'd1, 1, 3'd2, 5'd4, 0, 32'h0000_0003, 0, 0, 0, "R9 narrow lo");
      chk_reg(2'd1, 3'd3, 8'd4, 64'hCAFE_0001_0000_0003, "R9 narrow lo");
      op(4'd1, 1, 3'd2, 5'd4, 1, 32'hDEAD_DEAD, 1, 1, 0, "R9 narrow hi");
      chk_reg(2'd1, 3'd3, 8'd4, 64'hCAFE_0001_0000_0003, "R9 narrow hi no write");
      fpr_wide = 1'b1;

      // R10 FP control, all cause bits set
      op(4'd1, 1, 3'd3, 5'd31, 0, 32'hFFFF_FFFF, 0, 0, 0, "R10");
      chk_reg(2'd1, 3'd4, 8'd31, 64'h0000_0000_FFFF_FFFF, "R10");

      // R11 reserved selects
      op(4'd1, 1, 3'd5, 5'd0, 0, 32'h0000_0055, 1, 1, 0, "R11 sel5");
      op(4'd1, 1, 3'd4, 5'd0, 0, 32'h0000_0044, 1, 1, 0, "R11 sel4");
      chk_reg(2'd1, 3'd0, 8'd0, 64'd0, "R11 no write");

      // R3 virtual-processor permission
      op(4'd2, 1, 3'd0, 5'd1, 0, 32'h0000_0011, 1, 0, 0, "R3 blocked");
      chk_reg(2'd2, 3'd0, 8'd1, 64'd0, "R3 blocked no write");
      mvp_priv = 1'b1;
      op(4'd2, 1, 3'd0, 5'd1, 0, 32'h0000_0011, 0, 0, 0, "R3 privileged");
      chk_reg(2'd2, 3'd0, 8'd1, 64'h11, "R3 privileged");
      mvp_priv = 1'b0;
      // permission block beats an illegal encoding
      op(4'd2, 1, 3'd1, 5'd3, 0, 32'h0000_0033, 1, 0, 0, "R3 blocked illegal");

      // R4 range
      mvp_priv = 1'b1; top_ctx = 4'd2;
      op(4'd3, 1, 3'd0, 5'd2, 0, 32'h0000_0022, 1, 0, 0, "R4 above top");
      chk_reg(2'd3, 3'd0, 8'd2, 64'd0, "R4 above top no write");
      top_ctx = 4'd3;
      op(4'd3, 1, 3'd0, 5'd2, 0, 32'h0000_0022, 0, 0, 0, "R4 in range");
      chk_reg(2'd3, 3'd0, 8'd2, 64'h22, "R4 in range");
      top_ctx = 4'd15;
      op(4'd9, 1, 3'd0, 5'd9, 0, 32'h0000_0099, 1, 0, 0, "R4 beyond phys");
      chk_reg(2'd1, 3'd0, 8'd9, 64'd0, "R4 beyond phys no alias");
      top_ctx = 4'd3; mvp_priv = 1'b0;

      // R2 coprocessor disabled, alone and with an illegal code
      cp0_en = 1'b0;
      op(4'd1, 1, 3'd0, 5'd6, 0, 32'h0000_0066, 1, 0, 1, "R2 disabled");
      chk_reg(2'd1, 3'd0, 8'd6, 64'd0, "R2 no write");
      op(4'd1, 1, 3'd1, 5'd3, 0, 32'h0000_0077, 1, 0, 1, "R2 beats illegal");
      chk_reg(2'd1, 3'd1, 8'd3, 64'd0, "R2 beats illegal no write");
      cp0_en = 1'b1;

      // R1 back-to-back strobes
      drive(4'd1, 1, 3'd0, 5'd10, 0, 32'h0000_000A, 0, 0, 0, "R1 first");
      drive(4'd1, 1, 3'd0, 5'd11, 0, 32'h0000_000B, 0, 0, 0, "R1 second");
      idle();
      chk_bit(done, 1'b0, "R1 done drops");
      chk_reg(2'd1, 3'd0, 8'd10, 64'hA, "R1 first write");
      chk_reg(2'd1, 3'd0, 8'd11, 64'hB, "R1 second write");

      idle();
      chk_bit(sb.size() == 0, 1'b1, "R1 all strobes completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule